// File: doc/BRIEF.md
# Legacy Memory Window Address Decoder

This block sits between a real-mode address generator and the backing stores of a 1 MB legacy address space. Each request carries a 20-bit address, an access size (byte, word or dword) and a read/write flag. The block works out which store serves the request and passes on the offset relative to that store. The stores are an option-ROM image, a video frame buffer and main memory. For a small set of identification bytes at the very top of the space, no store is used: the block builds the read value itself.

Two controls change the decode. The first is a frame-buffer emulation enable. When it is set, the whole frame-buffer window reads as zero and drops writes. The second is a pair of configuration values: the last address of the ROM image and the size of main memory. Both are captured while reset is held. Requests in the gap between the ROM limit and the end of the ROM area are sent to main-memory offset 0 and marked as suspect. Requests past the end of main memory are sent to offset 0 and raise a halt. Every request gets a registered response one clock later, with a valid strobe.

Top module: `legacy_window_decoder`

## Requirements
- R1: A response appears exactly one clock after its request. `rsp_valid` equals the `req_valid` of the previous cycle, and it is 0 during and straight after reset.
- R2: An address from 0xC0000 up to the captured ROM limit is sent to the ROM region (code 1) at offset addr-0xC0000. Writes are forwarded (`rsp_wr_en` = `req_write`).
- R3: An address above the ROM limit and below 0xD0000 goes to main memory (code 0) at offset 0 with `rsp_suspect` set. Writes are forwarded and `rsp_halt` stays 0.
- R4: With emulation off, an address from 0xA0000 to 0xBFFFF goes to the frame-buffer region (code 2) at offset addr-0xA0000. Writes are forwarded.
- R5: With emulation on, an address from 0xA0000 to 0xBFFFF gives the null region (code 4) with offset 0, `rsp_data` 0 and `rsp_wr_en` 0.
- R6: Addresses 0xFFFF5 to 0xFFFFF give the identification region (code 3) at offset addr-0xFFFF5, and writes there are dropped. The byte values are the ASCII characters of "03/27/97" at 0xFFFF5..0xFFFFC, then 0x00 at 0xFFFFD, 0xFC at 0xFFFFE and 0x00 at 0xFFFFF.
- R7: Identification reads are little-endian. Byte lane i of `rsp_data` (bits 8i+7..8i) holds the byte at addr+i for the lanes the size covers: size code 0 covers 1 lane, code 1 covers 2 lanes and code 2 covers 4 lanes. Unused lanes, and lanes whose address lies past 0xFFFFF, read 0x00. Every other region returns `rsp_data` = 0.
- R8: An address that no rule above claims and that is at or past the captured main-memory size goes to main memory at offset 0 with `rsp_halt` set. Writes are dropped.
- R9: Any other address goes to main memory at offset equal to the address, with writes forwarded. `rsp_size` repeats the request size.
- R10: The ROM limit and the memory size are captured only while reset is high, so later changes on those inputs have no effect. A ROM limit below 0xC0000 is clamped to 0xC0000, and one above 0xCFFFF is clamped to 0xCFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the configuration |
| cfg_rom_limit | input | 20 | Last address of the ROM image, captured during reset |
| cfg_mem_size | input | 21 | Main memory size in bytes, captured during reset |
| emu_fb_en | input | 1 | Frame-buffer emulation enable |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 20 | Request address |
| req_size | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| req_write | input | 1 | 1 for a write, 0 for a read |
| rsp_valid | output | 1 | Response strobe |
| rsp_region | output | 3 | Region code: 0 main, 1 ROM, 2 frame buffer, 3 identification, 4 null |
| rsp_offset | output | 20 | Offset inside the selected region |
| rsp_size | output | 2 | Size of the request, passed through |
| rsp_wr_en | output | 1 | Write may go to the selected region |
| rsp_data | output | 32 | Fabricated read value (identification bytes, else zero) |
| rsp_suspect | output | 1 | Address lies in the gap above the ROM limit |
| rsp_halt | output | 1 | Address lies past the end of main memory |

## Verification
The bench walks the entire 1 MB space in 1 KB steps, with a low-bit pattern that changes from step to step. It adds every window edge, both sides of the ROM limit and of the memory size, and every top-of-space address. Each address is tried with all three sizes and with emulation both off and on. Three configurations are used. One has a mid-range ROM limit and half-size memory, which yields a suspect gap and a halt band below the frame buffer. One has a limit below the ROM area, which is clamped and gives the widest suspect gap, plus full memory. One has a limit above the ROM area, which is clamped and gives no gap. After each reset, the configuration inputs are changed to other values. The sweeps therefore tell priority errors, off-by-one window edges, a wrong clamp, lane order, and capture outside reset apart from one another.

// File: rtl/legacy_window_pkg.sv
package legacy_window_pkg;

    localparam int ADDR_W = 20;
    localparam int LANES  = 4;
    localparam int DATA_W = 8 * LANES;

    localparam logic [ADDR_W-1:0] FB_BASE     = 20'hA0000;
    localparam logic [ADDR_W-1:0] FB_LAST     = 20'hBFFFF;
    localparam logic [ADDR_W-1:0] ROM_BASE    = 20'hC0000;
    localparam logic [ADDR_W-1:0] ROM_CEIL    = 20'hCFFFF;
    localparam logic [ADDR_W-1:0] GAP_END     = 20'hD0000;
    localparam logic [ADDR_W-1:0] ID_BASE     = 20'hFFFF5;
    localparam logic [ADDR_W-1:0] TOP_ADDR    = 20'hFFFFF;

    localparam logic [63:0] ID_DATE     = "03/27/97";
    localparam logic [7:0]  ID_MODEL    = 8'hFC;
    localparam logic [7:0]  ID_SUBMODEL = 8'h00;

    typedef enum logic [2:0] {
        RGN_MAIN = 3'd0,
        RGN_ROM  = 3'd1,
        RGN_FB   = 3'd2,
        RGN_ID   = 3'd3,
        RGN_NULL = 3'd4
    } region_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } size_e;

    typedef struct packed {
        region_e            region;
        logic [ADDR_W-1:0]  offset;
        logic               suspect;
        logic               halt;
        logic               wr_ok;
    } decode_t;

    // Number of byte lanes a size code covers; codes past dword use all lanes.
    function automatic int lane_count(input logic [1:0] sz);
        case (sz)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 4;
        endcase
    endfunction

    // Constant byte at a top-of-space address (one bit wider so that a
    // lane address that ran past the top reads as zero).
    function automatic logic [7:0] id_byte(input logic [ADDR_W:0] a);
        logic [ADDR_W:0] k;
        logic [7:0]      b;
        int              idx;
        k   = a - {1'b0, ID_BASE};
        b   = 8'h00;
        idx = int'(k[3:0]);
        if (a >= {1'b0, ID_BASE} && a <= {1'b0, TOP_ADDR}) begin
            if (k[3:0] < 4'd8)       b = ID_DATE[8*(7-idx) +: 8];
            else if (k[3:0] == 4'd9) b = ID_MODEL;
            else if (k[3:0] == 4'd10) b = ID_SUBMODEL;
            else                      b = 8'h00;
        end
        return b;
    endfunction

endpackage

// File: rtl/lwd_cfg_latch.sv
module lwd_cfg_latch
    import legacy_window_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_rom_limit,
    input  logic [ADDR_W:0]   cfg_mem_size,
    output logic [ADDR_W-1:0] rom_limit_q,
    output logic [ADDR_W:0]   mem_size_q
);

    logic [ADDR_W-1:0] limit_clamped;

    always_comb begin
        if (cfg_rom_limit < ROM_BASE)      limit_clamped = ROM_BASE;
        else if (cfg_rom_limit > ROM_CEIL) limit_clamped = ROM_CEIL;
        else                               limit_clamped = cfg_rom_limit;
    end

    // Configuration is captured only while reset is held.
    always_ff @(posedge clk) begin
        if (rst) begin
            rom_limit_q <= limit_clamped;
            mem_size_q  <= cfg_mem_size;
        end
    end

endmodule

// File: rtl/lwd_window_decode.sv
module lwd_window_decode
    import legacy_window_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              emu_en,
    input  logic [ADDR_W-1:0] rom_limit,
    input  logic [ADDR_W:0]   mem_size,
    output decode_t           dec
);

    logic in_rom, in_gap, in_fb, in_id, beyond;

    assign in_rom = (addr >= ROM_BASE) && (addr <= rom_limit);
    assign in_gap = (addr > rom_limit) && (addr < GAP_END);
    assign in_fb  = (addr >= FB_BASE) && (addr <= FB_LAST);
    assign in_id  = (addr >= ID_BASE);
    assign beyond = ({1'b0, addr} >= mem_size);

    // Priority order matters: ROM, gap, frame buffer, ID bytes, range, main.
    always_comb begin
        dec.region  = RGN_MAIN;
        dec.offset  = addr;
        dec.suspect = 1'b0;
        dec.halt    = 1'b0;
        dec.wr_ok   = 1'b1;
        if (in_rom) begin
            dec.region = RGN_ROM;
            dec.offset = addr - ROM_BASE;
        end else if (in_gap) begin
            dec.offset  = '0;
            dec.suspect = 1'b1;
        end else if (in_fb) begin
            if (emu_en) begin
                dec.region = RGN_NULL;
                dec.offset = '0;
                dec.wr_ok  = 1'b0;
            end else begin
                dec.region = RGN_FB;
                dec.offset = addr - FB_BASE;
            end
        end else if (in_id) begin
            dec.region = RGN_ID;
            dec.offset = addr - ID_BASE;
            dec.wr_ok  = 1'b0;
        end else if (beyond) begin
            dec.offset = '0;
            dec.halt   = 1'b1;
            dec.wr_ok  = 1'b0;
        end
    end

endmodule

// File: rtl/lwd_id_lanes.sv
module lwd_id_lanes
    import legacy_window_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  region_e           region,
    output logic [DATA_W-1:0] data
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [ADDR_W:0] lane_addr;
        logic            lane_used;
        assign lane_addr = {1'b0, addr} + (ADDR_W+1)'(i);
        assign lane_used = (region == RGN_ID) && (i < lane_count(size));
        assign data[8*i +: 8] = lane_used ? id_byte(lane_addr) : 8'h00;
    end

endmodule

// File: rtl/legacy_window_decoder.sv
module legacy_window_decoder
    import legacy_window_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [19:0]       cfg_rom_limit,
    input  logic [20:0]       cfg_mem_size,
    input  logic              emu_fb_en,
    input  logic              req_valid,
    input  logic [19:0]       req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [2:0]        rsp_region,
    output logic [19:0]       rsp_offset,
    output logic [1:0]        rsp_size,
    output logic              rsp_wr_en,
    output logic [31:0]       rsp_data,
    output logic              rsp_suspect,
    output logic              rsp_halt
);

    logic [ADDR_W-1:0] rom_limit_q;
    logic [ADDR_W:0]   mem_size_q;
    decode_t           dec;
    logic [DATA_W-1:0] lane_data;

    lwd_cfg_latch u_cfg (
        .clk           (clk),
        .rst           (rst),
        .cfg_rom_limit (cfg_rom_limit),
        .cfg_mem_size  (cfg_mem_size),
        .rom_limit_q   (rom_limit_q),
        .mem_size_q    (mem_size_q)
    );

    lwd_window_decode u_dec (
        .addr      (req_addr),
        .emu_en    (emu_fb_en),
        .rom_limit (rom_limit_q),
        .mem_size  (mem_size_q),
        .dec       (dec)
    );

    lwd_id_lanes u_lanes (
        .addr   (req_addr),
        .size   (req_size),
        .region (dec.region),
        .data   (lane_data)
    );

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_valid   <= 1'b0;
            rsp_region  <= RGN_MAIN;
            rsp_offset  <= '0;
            rsp_size    <= '0;
            rsp_wr_en   <= 1'b0;
            rsp_data    <= '0;
            rsp_suspect <= 1'b0;
            rsp_halt    <= 1'b0;
        end else begin
            rsp_valid   <= 1'b1;
            rsp_region  <= dec.region;
            rsp_offset  <= dec.offset;
            rsp_size    <= req_size;
            rsp_wr_en   <= req_write && dec.wr_ok;
            rsp_data    <= lane_data;
            rsp_suspect <= dec.suspect;
            rsp_halt    <= dec.halt;
        end
    end

endmodule

// File: rtl/lwd_checker.sv
module lwd_checker
    import legacy_window_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [19:0] cfg_rom_limit,
    input logic [20:0] cfg_mem_size,
    input logic        emu_fb_en,
    input logic        req_valid,
    input logic [19:0] req_addr,
    input logic [1:0]  req_size,
    input logic        req_write,
    input logic        rsp_valid,
    input logic [2:0]  rsp_region,
    input logic [19:0] rsp_offset,
    input logic [1:0]  rsp_size,
    input logic        rsp_wr_en,
    input logic [31:0] rsp_data,
    input logic        rsp_suspect,
    input logic        rsp_halt
);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r5_fb_masked: assert property (@(posedge clk) disable iff (rst)
        (req_valid && emu_fb_en && req_addr >= FB_BASE && req_addr <= FB_LAST)
        |=> (rsp_region == RGN_NULL && !rsp_wr_en && rsp_data == '0));

    a_r3_suspect_redirect: assert property (@(posedge clk) disable iff (rst)
        rsp_suspect |-> (rsp_region == RGN_MAIN && rsp_offset == '0 && !rsp_halt));

    a_r8_halt_redirect: assert property (@(posedge clk) disable iff (rst)
        rsp_halt |-> (rsp_region == RGN_MAIN && rsp_offset == '0 && !rsp_wr_en));

    a_r6_id_readonly: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_region == RGN_ID) |-> !rsp_wr_en);

    a_r9_size_passthru: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_size == $past(req_size));

endmodule

bind legacy_window_decoder lwd_checker u_chk (.*);

// File: tb/legacy_window_decoder_test.sv
module legacy_window_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] cfg_rom_limit = '0;
    logic [20:0] cfg_mem_size = '0;
    logic        emu_fb_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_region;
    logic [19:0] rsp_offset;
    logic [1:0]  rsp_size;
    logic        rsp_wr_en;
    logic [31:0] rsp_data;
    logic        rsp_suspect;
    logic        rsp_halt;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [19:0] lim_eff;
    logic [20:0] msz_eff;

    legacy_window_decoder uut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: run hung, cycles=%0d expected below 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [7:0] exp_id(input logic [20:0] a);
        string ds = "03/27/97";
        int k;
        if (a < 21'hFFFF5 || a > 21'hFFFFF) return 8'h00;
        k = int'(a - 21'hFFFF5);
        if (k < 8)  return ds[k];
        if (k == 9) return 8'hFC;
        return 8'h00;
    endfunction

    task automatic model(input logic [19:0] a, input logic [1:0] sz, input logic wr,
                         input logic emu, output logic [2:0] rg, output logic [19:0] off,
                         output logic [31:0] d, output logic we, output logic sus,
                         output logic hlt, output string tag);
        rg = 3'd0; off = a; d = '0; we = wr; sus = 0; hlt = 0; tag = "R9";
        if (a >= 20'hC0000 && a <= lim_eff) begin
            rg = 3'd1; off = a - 20'hC0000; tag = "R2";
        end else if (a > lim_eff && a < 20'hD0000) begin
            off = 0; sus = 1; tag = "R3";
        end else if (a >= 20'hA0000 && a <= 20'hBFFFF) begin
            if (emu) begin rg = 3'd4; off = 0; we = 0; tag = "R5"; end
            else begin rg = 3'd2; off = a - 20'hA0000; tag = "R4"; end
        end else if (a >= 20'hFFFF5) begin
            rg = 3'd3; off = a - 20'hFFFF5; we = 0;
            tag = (sz == 2'd0) ? "R6" : "R7";
            for (int i = 0; i < (1 << sz); i++) d[8*i +: 8] = exp_id({1'b0, a} + 21'(i));
        end else if ({1'b0, a} >= msz_eff) begin
            off = 0; hlt = 1; we = 0; tag = "R8";
        end
        if (a == lim_eff || a == lim_eff + 20'd1) tag = {tag, "+R10"};
    endtask

    task automatic txn(input logic [19:0] a, input logic [1:0] sz, input logic wr,
                       input logic emu);
        logic [2:0] rg; logic [19:0] off; logic [31:0] d; logic we, sus, hlt; string tag;
        model(a, sz, wr, emu, rg, off, d, we, sus, hlt, tag);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_size = sz; req_write = wr; emu_fb_en = emu;
        @(negedge clk);
        req_valid = 0;
        checks++;
        if (rsp_valid !== 1'b1 || rsp_region !== rg || rsp_offset !== off ||
            rsp_data !== d || rsp_wr_en !== we || rsp_suspect !== sus ||
            rsp_halt !== hlt || rsp_size !== sz) begin
            failures++;
            $display("FAIL %s/R1 addr=%05h sz=%0d emu=%0d: got v=%0d rg=%0d off=%05h d=%08h we=%0d s=%0d h=%0d sz=%0d exp v=1 rg=%0d off=%05h d=%08h we=%0d s=%0d h=%0d",
                     tag, a, sz, emu, rsp_valid, rsp_region, rsp_offset, rsp_data,
                     rsp_wr_en, rsp_suspect, rsp_halt, rsp_size, rg, off, d, we, sus, hlt);
        end
    endtask

    task automatic sweep_cfg(input logic [19:0] raw_lim, input logic [20:0] msz);
        lim_eff = (raw_lim < 20'hC0000) ? 20'hC0000 :
                  (raw_lim > 20'hCFFFF) ? 20'hCFFFF : raw_lim;
        msz_eff = msz;
        @(negedge clk);
        rst = 1; cfg_rom_limit = raw_lim; cfg_mem_size = msz;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (rsp_valid !== 1'b0 || rsp_wr_en !== 1'b0 || rsp_halt !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset state: got v=%0d we=%0d h=%0d exp 0 0 0",
                     rsp_valid, rsp_wr_en, rsp_halt);
        end
        rst = 0;
        // R10: scramble the configuration inputs after reset
        cfg_rom_limit = ~raw_lim; cfg_mem_size = 21'h000100;
        for (int j = 0; j < 1024; j++) begin
            logic [19:0] a;
            a = 20'(j * 1024 + ((j * 37) % 1024));
            for (int s = 0; s < 3; s++)
                for (int e = 0; e < 2; e++)
                    txn(a, 2'(s), a[0] ^ s[0], e[0]);
        end
        begin
            logic [19:0] edges [12];
            edges = '{20'h00000, 20'h9FFFF, 20'hA0000, 20'hBFFFF, 20'hC0000,
                      lim_eff, lim_eff + 20'd1, 20'hCFFFF, 20'hD0000,
                      20'(msz - 21'd1), 20'(msz), 20'hFFFF4};
            foreach (edges[k])
                for (int s = 0; s < 3; s++)
                    for (int e = 0; e < 2; e++)
                        txn(edges[k], 2'(s), 1'b1, e[0]);
        end
        for (int t = 20'hFFFF0; t <= 20'hFFFFF; t++)
            for (int s = 0; s < 3; s++)
                txn(20'(t), 2'(s), 1'b1, 1'b0);
        // R1: idle cycle after a response
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 idle: got v=%0d exp 0", rsp_valid);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        sweep_cfg(20'hC7FFF, 21'h080000);
        sweep_cfg(20'hB0000, 21'h100000);
        sweep_cfg(20'hDFFFF, 21'h0A0000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule